// File: doc/BRIEF.md
# SPI Register-Access Slave Bridge

An SPI slave (mode 0) that lets an external host read and write single 32-bit words of an internal register space. A frame opens with chip select going low, followed by a 24-bit command: a write flag in the top bit and a 23-bit word address, always sent big-endian and MSB-first. A 32-bit payload follows. Read frames insert a programmable number of dummy bytes before the payload, which gives the internal bus time to answer.

SCK, chip select and MOSI are oversampled in the system clock domain. Word addresses 0 and 1 are served by two local registers. The order register selects the payload byte and bit order. The configuration/status register holds the padding count, a sticky flag for reads whose padding was too short, and a fixed interface number. Every other address becomes a request/acknowledge transaction on the internal bus.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, `miso_o` and `bus_req_o` are 0. The order register reads as order 00, and the configuration/status register reads 0x02000000 (zero padding, flag clear).
- R2: The 24 command bits are taken MSB-first. Command bit 23 = 1 marks a write and bit 23 = 0 marks a read. Bits 22:0 are the word address, which appears unchanged on `bus_addr_o`.
- R3: A 2-bit order field sets the payload order. Bit 0 = 1 sends the byte holding bits 31:24 first, while bit 0 = 0 sends the byte holding bits 7:0 first. Bit 1 = 1 sends each byte LSB-first, while bit 1 = 0 sends each byte MSB-first. The same order applies to written and read payloads.
- R4: Word address 0 is the order register. A write takes decoded bits 1:0 as the new order. A read returns every byte as {f[0], f[1], 0000, f[1], f[0]}, where f is the order field. This pattern decodes the same under all four orders.
- R5: Word address 1 bits 3:0 hold the padding count P. A read frame carries 8·P dummy bits, driven as 0 on MISO, between the command and the payload. The count changes only on a write to address 1.
- R6: Bits 31:24 of word address 1 always read 2, the interface number of this serial port.
- R7: A read of a bus address whose acknowledge has not arrived when the first payload bit is due returns all zeros and sets bit 16 of word address 1.
- R8: Bit 16 is sticky. It clears only on a write to address 1 with bit 16 set, or on reset. A write with bit 16 clear leaves it set.
- R9: Raising chip select aborts the frame. A partial write issues no bus transaction, and MISO returns to 0.
- R10: A bus read request is issued right after the last command bit. A bus write is issued only after all 32 payload bits have arrived. A request holds its address and direction until it is acknowledged.
- R11: A reset in mid-operation restores order 00 and zero padding and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| bus_req_o | output | 1 | Internal bus request, held until acknowledge |
| bus_we_o | output | 1 | Internal bus direction, 1 = write |
| bus_addr_o | output | 23 | Internal bus word address |
| bus_wdata_o | output | 32 | Internal bus write data |
| bus_ack_i | input | 1 | Internal bus acknowledge, one-cycle pulse |
| bus_rdata_i | input | 32 | Internal bus read data, valid with acknowledge |

## Verification
The hardest case to reach is an acknowledge that arrives after the first payload bit is due. The bench's bus responder has a programmable acknowledge delay. It is set beyond the six-clock window of a zero-padding read, and set inside the window of a two-byte-padding read, so the same access lands on both sides of the deadline. Chip select is also raised part-way through a write payload, and the bench confirms at the bus port that no write was issued.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ORD_LE_MSB = 2'b00,
    ORD_BE_MSB = 2'b01,
    ORD_LE_LSB = 2'b10,
    ORD_BE_LSB = 2'b11
  } ord_e;

  // order field replicated so that any current order decodes it the same
  function automatic logic [WORD_W-1:0] ord_pattern(logic [1:0] o);
    return {4{o[0], o[1], 4'b0000, o[1], o[0]}};
  endfunction
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      q_o  <= RST;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/sbr_order.sv
module sbr_order
  import sbr_pkg::*;
(
  input  logic [1:0]        ord_i,
  input  logic [WORD_W-1:0] word_i,  // word to serialize
  output logic [WORD_W-1:0] ser_o,   // bit 31 leaves first
  input  logic [WORD_W-1:0] ser_i,   // bit 31 arrived first
  output logic [WORD_W-1:0] word_o
);
  // position map is an involution, so one map serves both directions
  for (genvar n = 0; n < WORD_W; n++) begin : g_bit
    localparam int B = n / 8;
    localparam int I = n % 8;
    logic [4:0] pos;
    always_comb pos = 5'((ord_i[0] ? (3 - B) : B) * 8 + (ord_i[1] ? I : (7 - I)));
    assign word_o[n]          = ser_i[5'd31 - pos];
    assign ser_o[WORD_W-1-n]  = word_i[pos];
  end
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import sbr_pkg::*;
#(
  parameter int          ADDR_W = 23,
  parameter int          PAD_W  = 4,
  parameter logic [7:0]  IF_ID  = 8'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  localparam int CMD_W   = ADDR_W + 1;
  localparam int CNT_MAX = CMD_W + 8 * ((1 << PAD_W) - 1) + WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_WR  = CNT_W'(CMD_W + WORD_W - 1);

  logic [2:0] sync_q;
  logic       sck_prev_q;
  logic       cs_act, sck_rise, sck_fall, mosi_s;

  sbr_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, mosi_i}),
    .q_o   (sync_q)
  );

  assign cs_act   = ~sync_q[2];
  assign sck_rise = sync_q[1] & ~sck_prev_q;
  assign sck_fall = ~sync_q[1] & sck_prev_q;
  assign mosi_s   = sync_q[0];

  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  cmd_sr;
  logic [WORD_W-1:0] rx_sr, tx_sr, rd_q;
  logic              frm_wr_q, rd_done_q, too_fast_q;
  logic [ADDR_W-1:0] frm_addr_q;
  logic [1:0]        ord_q;
  logic [PAD_W-1:0]  pad_q;

  logic [CMD_W-1:0]  cmd_next;
  logic [WORD_W-1:0] rx_next, rd_word, tx_load, wr_word, cfg_rd;
  logic [CNT_W-1:0]  rd_start;
  logic              frm_local, commit, cfg_wr, ord_wr, cfg_clr, load, fast_miss;

  assign cmd_next  = {cmd_sr[CMD_W-2:0], mosi_s};
  assign rx_next   = {rx_sr[WORD_W-2:0], mosi_s};
  assign frm_local = (frm_addr_q[ADDR_W-1:1] == '0);
  assign rd_start  = CNT_W'(CMD_W) + CNT_W'({pad_q, 3'b000});
  assign commit    = cs_act && sck_rise && frm_wr_q && (bit_cnt == LAST_WR);
  assign cfg_wr    = commit && (frm_addr_q == ADDR_W'(1));
  assign ord_wr    = commit && (frm_addr_q == '0);
  assign cfg_clr   = cfg_wr && wr_word[16];
  assign load      = cs_act && sck_fall && !frm_wr_q && (bit_cnt == rd_start);
  assign fast_miss = load && !frm_local && !rd_done_q;
  assign cfg_rd    = {IF_ID, 7'b0, too_fast_q, 16'(pad_q)};

  always_comb begin
    if (frm_addr_q == '0)                rd_word = ord_pattern(ord_q);
    else if (frm_addr_q == ADDR_W'(1))   rd_word = cfg_rd;
    else if (rd_done_q)                  rd_word = rd_q;
    else                                 rd_word = '0;
  end

  sbr_order u_order (
    .ord_i (ord_q),
    .word_i(rd_word),
    .ser_o (tx_load),
    .ser_i (rx_next),
    .word_o(wr_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q  <= 1'b0;
      bit_cnt     <= '0;
      cmd_sr      <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      rd_q        <= '0;
      frm_wr_q    <= 1'b0;
      frm_addr_q  <= '0;
      rd_done_q   <= 1'b0;
      too_fast_q  <= 1'b0;
      ord_q       <= ORD_LE_MSB;
      pad_q       <= '0;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else begin
      sck_prev_q <= sync_q[1];
      if (bus_req_o && bus_ack_i) begin
        bus_req_o <= 1'b0;
        if (!bus_we_o) begin
          rd_q      <= bus_rdata_i;
          rd_done_q <= 1'b1;
        end
      end
      if (!cs_act) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else if (sck_rise) begin
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CNT_W'(CMD_W)) cmd_sr <= cmd_next;
        else                         rx_sr  <= rx_next;
        if (bit_cnt == LAST_CMD) begin
          frm_wr_q   <= cmd_next[CMD_W-1];
          frm_addr_q <= cmd_next[ADDR_W-1:0];
          // bus read launched as soon as the address is complete
          if (!cmd_next[CMD_W-1] && (cmd_next[ADDR_W-1:1] != '0) && !bus_req_o) begin
            bus_req_o  <= 1'b1;
            bus_we_o   <= 1'b0;
            bus_addr_o <= cmd_next[ADDR_W-1:0];
            rd_done_q  <= 1'b0;
          end
        end
        if (commit && !frm_local && !bus_req_o) begin
          bus_req_o   <= 1'b1;
          bus_we_o    <= 1'b1;
          bus_addr_o  <= frm_addr_q;
          bus_wdata_o <= wr_word;
        end
      end else if (sck_fall && !frm_wr_q && (bit_cnt >= CNT_W'(CMD_W))) begin
        if (bit_cnt == rd_start) tx_sr <= tx_load;
        else                     tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      end
      if (ord_wr) ord_q <= wr_word[1:0];
      if (cfg_wr) pad_q <= wr_word[PAD_W-1:0];
      if (fast_miss)    too_fast_q <= 1'b1;
      else if (cfg_clr) too_fast_q <= 1'b0;
    end
  end

  assign miso_o = tx_sr[WORD_W-1];
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int ADDR_W = 23,
  parameter int PAD_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic              bus_ack_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              too_fast_q,
  input logic [PAD_W-1:0]  pad_q,
  input logic              cfg_wr,
  input logic              cfg_clr
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  // R9
  idle_miso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_o);

  // R8
  sticky_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(too_fast_q) |-> $past(cfg_clr));

  // R5
  pad_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pad_q) |-> $past(cfg_wr));

  // R7
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(too_fast_q) |-> !$past(cs_ni));
endmodule

bind spi_reg_bridge sbr_checker #(.ADDR_W(ADDR_W), .PAD_W(PAD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .bus_req_o (bus_req_o),
  .bus_we_o  (bus_we_o),
  .bus_ack_i (bus_ack_i),
  .bus_addr_o(bus_addr_o),
  .too_fast_q(too_fast_q),
  .pad_q     (pad_q),
  .cfg_wr    (cfg_wr),
  .cfg_clr   (cfg_clr)
);

// File: tb/spi_reg_bridge_bench.sv
module spi_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, bus_req, bus_we, bus_ack = 1'b0;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;

  always #4 clk = ~clk;

  spi_reg_bridge u_spi_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [1:0]  m_ord = 2'b00;
  int          m_pad = 0;
  bit          m_sticky = 0;
  logic [31:0] mem [int];
  int          ack_delay = 1;
  int          bus_wr_cnt = 0;
  logic [22:0] last_wr_addr;
  logic [31:0] last_wr_data;
  bit          acked = 0;
  int          dcnt = 0;
  int          cs_hi = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [22:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  // bus responder and per-clock idle check
  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (!bus_req) begin
      acked = 0;
      dcnt  = 0;
    end else if (!acked) begin
      if (dcnt >= ack_delay) begin
        bus_ack = 1'b1;
        acked   = 1;
        if (bus_we) begin
          mem[int'(bus_addr)] = bus_wdata;
          bus_wr_cnt++;
          last_wr_addr = bus_addr;
          last_wr_data = bus_wdata;
        end else bus_rdata = mem_rd(bus_addr);
      end else dcnt++;
    end
    if (cs_n && rst_n) cs_hi++; else cs_hi = 0;
    if (cs_hi >= 5) chk("R9 idle miso", {31'b0, miso}, 32'h0);
  end

  function automatic int sidx(input int k, input logic [1:0] o);
    int n = k / 8;
    int m = k % 8;
    return (o[0] ? 3 - n : n) * 8 + (o[1] ? m : 7 - m);
  endfunction

  task automatic sck_bit(input logic b, output logic r);
    @(negedge clk) mosi = b;
    repeat (6) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [22:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output bit pad_ok, input int stop_at);
    logic [23:0] cmd;
    logic        r;
    cmd = {wr, a};
    pad_ok = 1;
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 23; i >= 0; i--) sck_bit(cmd[i], r);
    if (!wr) for (int i = 0; i < 8 * m_pad; i++) begin
      sck_bit(1'b0, r);
      if (r !== 1'b0) pad_ok = 0;
    end
    for (int k = 0; k < 32; k++) begin
      if (stop_at != 0 && k == stop_at) break;
      sck_bit(wr ? wd[sidx(k, m_ord)] : 1'b0, r);
      rd[sidx(k, m_ord)] = r;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    while (bus_req) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [22:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bit ok;
    xfer(1'b1, a, d, dummy, ok, 0);
    if (a == 23'd0) m_ord = d[1:0];
    if (a == 23'd1) begin
      m_pad = int'(d[3:0]);
      if (d[16]) m_sticky = 0;
    end
  endtask

  task automatic rd_reg(input logic [22:0] a, output logic [31:0] d, output bit ok);
    xfer(1'b0, a, 32'h0, d, ok, 0);
  endtask

  function automatic logic [31:0] exp_cfg();
    return {8'd2, 7'd0, m_sticky, 12'd0, 4'(m_pad)};
  endfunction

  function automatic logic [31:0] exp_ord(input logic [1:0] o);
    return {4{o[0], o[1], 4'b0000, o[1], o[0]}};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    logic [22:0] ta;
    int wc;
    repeat (5) @(negedge clk);
    chk("R1 miso reset", {31'b0, miso}, 32'h0);
    chk("R1 req reset", {31'b0, bus_req}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd_reg(23'd1, d, ok);
    chk("R1 R6 cfg reset", d, 32'h0200_0000);
    rd_reg(23'd0, d, ok);
    chk("R1 order reset", d, exp_ord(2'b00));

    // R2 R10: bus write then read back in order 00
    wr_reg(23'h001234, 32'hA1B2_C3D4);
    chk("R2 bus addr", {9'b0, last_wr_addr}, {9'b0, 23'h001234});
    chk("R10 bus wdata", last_wr_data, 32'hA1B2_C3D4);
    rd_reg(23'h001234, d, ok);
    chk("R3 R10 read 00", d, 32'hA1B2_C3D4);
    wr_reg(23'h7FFFFF, 32'h8000_0001);
    chk("R2 top addr", {9'b0, last_wr_addr}, {9'b0, 23'h7FFFFF});
    mem[2] = 32'h0F1E_2D3C;
    rd_reg(23'd2, d, ok);
    chk("R2 first bus addr read", d, 32'h0F1E_2D3C);

    // R3 R4: each order
    for (int o = 1; o < 4; o++) begin
      wr_reg(23'd0, exp_ord(2'(o)));
      rd_reg(23'd0, d, ok);
      chk("R4 order readback", d, exp_ord(2'(o)));
      ta = 23'(16 + o);
      wr_reg(ta, 32'h1357_9BDF ^ (32'(o) << 28));
      chk("R3 write decode", last_wr_data, 32'h1357_9BDF ^ (32'(o) << 28));
      mem[100 + o] = 32'hC0DE_0000 | 32'(o * 17);
      rd_reg(23'(100 + o), d, ok);
      chk("R3 read encode", d, 32'hC0DE_0000 | 32'(o * 17));
    end
    wr_reg(23'd0, exp_ord(2'b00));

    // R5: padding hides a slow acknowledge
    wr_reg(23'd1, 32'h0000_0002);
    rd_reg(23'd1, d, ok);
    chk("R5 R6 cfg pad", d, exp_cfg());
    ack_delay = 60;
    mem[300] = 32'h5566_7788;
    rd_reg(23'd300, d, ok);
    chk("R5 padded read", d, 32'h5566_7788);
    chk("R5 pad bits zero", {31'b0, ok}, 32'h1);

    // R7: too little padding
    wr_reg(23'd1, 32'h0000_0000);
    ack_delay = 100;
    rd_reg(23'd300, d, ok);
    chk("R7 late data zero", d, 32'h0);
    m_sticky = 1;
    ack_delay = 1;
    rd_reg(23'd1, d, ok);
    chk("R7 flag set", d, exp_cfg());

    // R8: sticky clear rules
    wr_reg(23'd1, 32'h0000_0000);
    rd_reg(23'd1, d, ok);
    chk("R8 flag kept", d, exp_cfg());
    chk("R8 flag kept bit", {31'b0, d[16]}, 32'h1);
    wr_reg(23'd1, 32'h0001_0000);
    rd_reg(23'd1, d, ok);
    chk("R8 flag cleared", d, 32'h0200_0000);

    // R9: aborted write
    wc = bus_wr_cnt;
    mem[400] = 32'h0BAD_F00D;
    begin
      logic [31:0] dd;
      bit k;
      xfer(1'b1, 23'd400, 32'hFFFF_FFFF, dd, k, 20);
    end
    chk("R9 no bus write", 32'(bus_wr_cnt), 32'(wc));
    rd_reg(23'd400, d, ok);
    chk("R9 mem unchanged", d, 32'h0BAD_F00D);

    // R11: reset restores defaults
    wr_reg(23'd0, exp_ord(2'b11));
    wr_reg(23'd1, 32'h0000_0001);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_ord = 2'b00;
    m_pad = 0;
    m_sticky = 0;
    repeat (4) @(negedge clk);
    rd_reg(23'd1, d, ok);
    chk("R11 cfg default", d, 32'h0200_0000);
    rd_reg(23'd0, d, ok);
    chk("R11 order default", d, exp_ord(2'b00));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule